// File: doc/BRIEF.md
# Paged Memory Download Window

This block is a register-level slave that sits behind a clause-22 style management register file. A host selects page 4 through the page-select register at address 0x1F. While that page is selected, a small set of window registers lets the host stream a binary image into a 32-bit internal memory space one 32-bit word at a time. Each word arrives as two 16-bit halves. The upper half is written first. The write of the lower half commits the word to a memory write port. When auto-increment mode is on, the target address then advances by one word.

A typical download runs as follows. The host selects page 4, raises the processor stall bit in the run-control window register, enables auto-increment, and loads a start address. It then writes the word halves for the first image. It reloads the address for a second image and writes its words. Finally it drops the stall bit, sets the start bit, and selects page 0 again. Each memory word leaves on a valid/ready port. A word is held, with a stable address and stable data, until the memory accepts it.

The register write port has no stall input from the host, so the block advertises `reg_ready`. This signal is low only while a committed word waits and the memory refuses it. A register write presented while `reg_ready` is low has no effect. In the cycle where the waiting word is accepted, `reg_ready` is already high, so a new register write, including the next commit, is taken in that same cycle.

Top module: `mdw_download_window`

## Requirements
- R1: After reset the page register reads 0, auto-increment is off, the address is 0, `mem_valid` is 0, `reg_ready` is 1, and both `cpu_hold` and `cpu_start` are 0.
- R2: Register 0x1F is the page register. It reads back its last written value on every page. The window registers (0x10 to 0x15) read their contents only while the page value is 4, and read 0 otherwise.
- R3: A write to any window register while the page is not 4 changes no window register and produces no memory write.
- R4: Register 0x10 is the mode register and reads back its last written value. Bit 15 set (for example 0x8000) turns auto-increment on, and bit 15 clear turns it off.
- R5: Writing register 0x11 loads address bits 31:16, and writing 0x12 loads bits 15:0. Reading them returns the current, possibly incremented, address halves.
- R6: Register 0x13 latches a word's upper half (bits 31:16) and register 0x14 its lower half (bits 15:0). Each write to 0x14 issues exactly one memory word {upper, lower} at the current address. Both registers read back their last written value.
- R7: After each commit with auto-increment on, the address advances by 4, carrying across bit 16. With auto-increment off, the address stays unchanged.
- R8: Writing 0x11 or 0x12 discards a pending upper half. A commit with no upper half written since the last commit or address load sends 0 in bits 31:16.
- R9: While `mem_valid` is 1 and `mem_ready` is 0, `mem_valid`, `mem_addr` and `mem_data` hold their values.
- R10: `reg_ready` is 0 while a word waits and `mem_ready` is 0, and a register write in such a cycle has no effect. In the cycle where the waiting word is accepted, a register write is taken.
- R11: Register 0x15 is the run-control register and reads back its last written value. Bit 11 drives `cpu_hold` and bit 0 drives `cpu_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register write address |
| reg_wdata | input | 16 | Register write data |
| reg_ready | output | 1 | Register write accepted when high |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| mem_valid | output | 1 | Memory word valid |
| mem_ready | input | 1 | Memory accepts the word |
| mem_addr | output | ADDR_W (32) | Memory word address |
| mem_data | output | 32 | Memory word data |
| cpu_hold | output | 1 | Embedded processor stall |
| cpu_start | output | 1 | Embedded processor start |

## Verification
Two functions can fall in the same cycle: the memory accepting a waiting word, and the register port taking the next write, which may itself be a new commit. The bench holds `mem_ready` low after a commit, tries a write that must be ignored, and queues an upper-half write. It then releases `mem_ready` and checks two things: the queued write is accepted in the handshake cycle itself, and the word after it arrives intact in the scoreboard. Streams with `mem_ready` toggling every cycle repeat this overlap for many consecutive words.

// File: rtl/mdw_pkg.sv
package mdw_pkg;
  localparam int REG_AW = 5;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;

  localparam logic [REG_AW-1:0] REG_PAGE = 5'h1F;
  localparam logic [REG_AW-1:0] REG_MODE = 5'h10;
  localparam logic [REG_AW-1:0] REG_AHI  = 5'h11;
  localparam logic [REG_AW-1:0] REG_ALO  = 5'h12;
  localparam logic [REG_AW-1:0] REG_DHI  = 5'h13;
  localparam logic [REG_AW-1:0] REG_DLO  = 5'h14;
  localparam logic [REG_AW-1:0] REG_RUN  = 5'h15;

  localparam int MODE_AINC_BIT = 15;
  localparam int RUN_HOLD_BIT  = 11;
  localparam int RUN_START_BIT = 0;

  typedef enum logic [2:0] {
    WSEL_NONE,
    WSEL_MODE,
    WSEL_AHI,
    WSEL_ALO,
    WSEL_DHI,
    WSEL_DLO,
    WSEL_RUN
  } wsel_e;
endpackage

// File: rtl/mdw_page_decode.sv
module mdw_page_decode
  import mdw_pkg::*;
#(
  parameter int WIN_PAGE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [HALF_W-1:0] wr_data,
  output logic [HALF_W-1:0] page_q,
  output logic              win_open,
  output wsel_e             wsel
);
  localparam logic [HALF_W-1:0] WIN_VAL = HALF_W'(WIN_PAGE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= '0;
    end else if (wr_fire && wr_addr == REG_PAGE) begin
      page_q <= wr_data;
    end
  end

  assign win_open = (page_q == WIN_VAL);

  always_comb begin
    wsel = WSEL_NONE;
    if (wr_fire && win_open) begin
      unique case (wr_addr)
        REG_MODE: wsel = WSEL_MODE;
        REG_AHI:  wsel = WSEL_AHI;
        REG_ALO:  wsel = WSEL_ALO;
        REG_DHI:  wsel = WSEL_DHI;
        REG_DLO:  wsel = WSEL_DLO;
        REG_RUN:  wsel = WSEL_RUN;
        default:  wsel = WSEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/mdw_addr_counter.sv
module mdw_addr_counter
  import mdw_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int ADDR_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_hi,
  input  logic              ld_lo,
  input  logic              advance,
  input  logic [HALF_W-1:0] wr_data,
  output logic [ADDR_W-1:0] addr_q,
  output logic [HALF_W-1:0] addr_hi_rd,
  output logic [HALF_W-1:0] addr_lo_rd
);
  localparam int HI_W = ADDR_W - HALF_W;
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(ADDR_STEP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (ld_hi) begin
      addr_q[ADDR_W-1:HALF_W] <= wr_data[HI_W-1:0];
    end else if (ld_lo) begin
      addr_q[HALF_W-1:0] <= wr_data;
    end else if (advance) begin
      addr_q <= addr_q + STEP_V;
    end
  end

  assign addr_lo_rd = addr_q[HALF_W-1:0];

  generate
    if (HI_W == HALF_W) begin : g_full_hi
      assign addr_hi_rd = addr_q[ADDR_W-1:HALF_W];
    end else begin : g_pad_hi
      assign addr_hi_rd = {{(HALF_W-HI_W){1'b0}}, addr_q[ADDR_W-1:HALF_W]};
    end
  endgenerate
endmodule

// File: rtl/mdw_word_stage.sv
module mdw_word_stage
  import mdw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dhi_wr,
  input  logic              dlo_wr,
  input  logic              discard,
  input  logic [HALF_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              mem_ready,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_data,
  output logic [HALF_W-1:0] upper_q,
  output logic [HALF_W-1:0] lower_q,
  output logic              pend_q,
  output logic              slot_free
);
  logic [HALF_W-1:0] upper_use;

  assign slot_free = !mem_valid || mem_ready;
  assign upper_use = pend_q ? upper_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upper_q <= '0;
      lower_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (dhi_wr) begin
        upper_q <= wr_data;
        pend_q  <= 1'b1;
      end
      if (discard) begin
        pend_q <= 1'b0;
      end
      if (dlo_wr) begin
        lower_q <= wr_data;
        pend_q  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      mem_addr  <= '0;
      mem_data  <= '0;
    end else if (dlo_wr) begin
      mem_valid <= 1'b1;
      mem_addr  <= cur_addr;
      mem_data  <= {upper_use, wr_data};
    end else if (mem_ready) begin
      mem_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mdw_ctrl_regs.sv
module mdw_ctrl_regs
  import mdw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic              run_wr,
  input  logic [HALF_W-1:0] wr_data,
  output logic [HALF_W-1:0] mode_q,
  output logic [HALF_W-1:0] run_q,
  output logic              ainc,
  output logic              cpu_hold,
  output logic              cpu_start
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      run_q  <= '0;
    end else begin
      if (mode_wr) mode_q <= wr_data;
      if (run_wr)  run_q  <= wr_data;
    end
  end

  assign ainc      = mode_q[MODE_AINC_BIT];
  assign cpu_hold  = run_q[RUN_HOLD_BIT];
  assign cpu_start = run_q[RUN_START_BIT];
endmodule

// File: rtl/mdw_download_window.sv
module mdw_download_window
  import mdw_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int WIN_PAGE  = 4,
  parameter int ADDR_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [4:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic              reg_ready,
  input  logic [4:0]        rd_addr,
  output logic [15:0]       rd_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_data,
  output logic              cpu_hold,
  output logic              cpu_start
);
  logic              wr_fire;
  logic [HALF_W-1:0] page_q;
  logic              win_open;
  wsel_e             wsel;
  logic [ADDR_W-1:0] addr_q;
  logic [HALF_W-1:0] addr_hi_rd, addr_lo_rd;
  logic [HALF_W-1:0] upper_q, lower_q, mode_q, run_q;
  logic              pend_q, slot_free, ainc;
  logic              commit;

  assign reg_ready = slot_free;
  assign wr_fire   = reg_we && slot_free;
  assign commit    = (wsel == WSEL_DLO);

  mdw_page_decode #(.WIN_PAGE(WIN_PAGE)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_addr(reg_addr),
    .wr_data(reg_wdata), .page_q(page_q), .win_open(win_open), .wsel(wsel)
  );

  mdw_addr_counter #(.ADDR_W(ADDR_W), .ADDR_STEP(ADDR_STEP)) u_addr (
    .clk(clk), .rst_n(rst_n),
    .ld_hi(wsel == WSEL_AHI), .ld_lo(wsel == WSEL_ALO),
    .advance(commit && ainc), .wr_data(reg_wdata),
    .addr_q(addr_q), .addr_hi_rd(addr_hi_rd), .addr_lo_rd(addr_lo_rd)
  );

  mdw_word_stage #(.ADDR_W(ADDR_W)) u_word (
    .clk(clk), .rst_n(rst_n),
    .dhi_wr(wsel == WSEL_DHI), .dlo_wr(commit),
    .discard(wsel == WSEL_AHI || wsel == WSEL_ALO),
    .wr_data(reg_wdata), .cur_addr(addr_q), .mem_ready(mem_ready),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
    .upper_q(upper_q), .lower_q(lower_q), .pend_q(pend_q), .slot_free(slot_free)
  );

  mdw_ctrl_regs u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .mode_wr(wsel == WSEL_MODE), .run_wr(wsel == WSEL_RUN),
    .wr_data(reg_wdata), .mode_q(mode_q), .run_q(run_q),
    .ainc(ainc), .cpu_hold(cpu_hold), .cpu_start(cpu_start)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == REG_PAGE) begin
      rd_data = page_q;
    end else if (win_open) begin
      unique case (rd_addr)
        REG_MODE: rd_data = mode_q;
        REG_AHI:  rd_data = addr_hi_rd;
        REG_ALO:  rd_data = addr_lo_rd;
        REG_DHI:  rd_data = upper_q;
        REG_DLO:  rd_data = lower_q;
        REG_RUN:  rd_data = run_q;
        default:  rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/mdw_download_window_chk.sv
module mdw_download_window_chk
  import mdw_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int WIN_PAGE  = 4,
  parameter int ADDR_STEP = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic              reg_ready,
  input logic [4:0]        reg_addr,
  input logic [15:0]       reg_wdata,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_data,
  input logic              cpu_hold,
  input logic [15:0]       page_q,
  input logic [ADDR_W-1:0] addr_q,
  input logic              pend_q,
  input logic              ainc
);
  localparam logic [15:0] WIN_VAL = 16'(WIN_PAGE);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(ADDR_STEP);

  logic in_win_fire;
  assign in_win_fire = reg_we && reg_ready && (page_q == WIN_VAL);

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

  // R3
  closed_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_valid && page_q != WIN_VAL) |=> !mem_valid);

  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win_fire && reg_addr == REG_DLO && ainc) |=>
      (mem_valid && mem_addr == $past(addr_q) && addr_q == $past(addr_q) + STEP_V));

  // R8
  discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win_fire && (reg_addr == REG_AHI || reg_addr == REG_ALO)) |=> !pend_q);

  // R6
  commit_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) |-> $past(in_win_fire && reg_addr == REG_DLO));

  // R10
  blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && reg_we) |=> ($stable(page_q) && $stable(addr_q) && $stable(cpu_hold)));

  // R11
  hold_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win_fire && reg_addr == REG_RUN) |=> (cpu_hold == $past(reg_wdata[RUN_HOLD_BIT])));
endmodule

bind mdw_download_window mdw_download_window_chk #(
  .ADDR_W(ADDR_W), .WIN_PAGE(WIN_PAGE), .ADDR_STEP(ADDR_STEP)
) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_ready(reg_ready),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
  .cpu_hold(cpu_hold), .page_q(page_q), .addr_q(addr_q), .pend_q(pend_q),
  .ainc(ainc)
);

// File: tb/mdw_download_window_tb_top.sv
module mdw_download_window_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        reg_ready;
  logic [4:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        mem_valid;
  logic        mem_ready = 1'b1;
  logic [31:0] mem_addr;
  logic [31:0] mem_data;
  logic        cpu_hold, cpu_start;

  always #5 clk = ~clk;

  mdw_download_window dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_ready(reg_ready), .rd_addr(rd_addr),
    .rd_data(rd_data), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .cpu_hold(cpu_hold),
    .cpu_start(cpu_start)
  );

  int checks = 0, fails = 0;
  int cyc = 0;
  int ready_mode = 1;   // 0 low, 1 high, 2 toggling
  int pushed = 0, popped = 0;
  int hs_cyc = -1, acc_cyc = -1;
  logic [63:0] exp_q[$];

  logic [15:0] m_page = '0;
  logic        m_ainc = 1'b0, m_pend = 1'b0;
  logic [15:0] m_upper = '0;
  logic [31:0] m_addr = '0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #2;
    case (ready_mode)
      0: mem_ready = 1'b0;
      1: mem_ready = 1'b1;
      default: mem_ready = ~mem_ready;
    endcase
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor: handshake happens at the posedge after this negedge
  initial begin
    forever begin
      @(negedge clk);
      if (mem_valid && mem_ready) begin
        hs_cyc = cyc + 1;
        popped++;
        if (exp_q.size() == 0) begin
          chk("R6 unexpected word", {mem_addr, mem_data}, 64'h0);
        end else begin
          chk("R6 word", {mem_addr, mem_data}, exp_q.pop_front());
        end
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    while (!reg_ready) @(negedge clk);
    @(posedge clk);
    #1 reg_we = 1'b0;
    acc_cyc = cyc;
    if (a == 5'h1F) m_page = d;
    else if (m_page == 16'd4) begin
      case (a)
        5'h10: m_ainc = d[15];
        5'h11: begin m_addr[31:16] = d; m_pend = 1'b0; end
        5'h12: begin m_addr[15:0] = d; m_pend = 1'b0; end
        5'h13: begin m_upper = d; m_pend = 1'b1; end
        5'h14: begin
          exp_q.push_back({m_addr, (m_pend ? m_upper : 16'h0), d});
          pushed++;
          m_pend = 1'b0;
          if (m_ainc) m_addr = m_addr + 32'd4;
        end
        default: ;
      endcase
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] v);
    @(negedge clk);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic word(input logic [31:0] w);
    wr(5'h13, w[31:16]);
    wr(5'h14, w[15:0]);
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    int base;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk("R1 mem_valid", mem_valid, 0);
    chk("R1 reg_ready", reg_ready, 1);
    chk("R1 hold/start", {cpu_hold, cpu_start}, 0);
    rd(5'h1F, v); chk("R1 page", v, 0);

    // R3 writes outside page 4 are ignored
    base = popped;
    wr(5'h10, 16'h8000); wr(5'h11, 16'h1234);
    wr(5'h13, 16'hAAAA); wr(5'h14, 16'hBBBB); wr(5'h15, 16'h0800);
    repeat (3) @(negedge clk);
    chk("R3 no memory write", popped - base, 0);
    chk("R3 hold untouched", cpu_hold, 0);
    rd(5'h10, v); chk("R2 window reads 0 off page", v, 0);
    wr(5'h1F, 16'd4);
    rd(5'h1F, v); chk("R2 page readback", v, 4);
    rd(5'h10, v); chk("R3 mode unchanged", v, 0);
    rd(5'h11, v); chk("R3 addr hi unchanged", v, 0);
    rd(5'h13, v); chk("R3 upper unchanged", v, 0);
    rd(5'h14, v); chk("R3 lower unchanged", v, 0);

    // R11 stall the processor
    wr(5'h15, 16'h0800);
    @(negedge clk);
    chk("R11 hold set", {cpu_hold, cpu_start}, 2'b10);

    // R4 R5 R7 first image at 0
    wr(5'h10, 16'h8000);
    rd(5'h10, v); chk("R4 mode readback", v, 16'h8000);
    wr(5'h11, 16'h0000); wr(5'h12, 16'h0000);
    for (int i = 0; i < 4; i++) word(32'hC0DE_0000 + 32'(i * 32'h0001_0101));
    drain();
    rd(5'h11, v); chk("R5 addr hi after stream", v, 0);
    rd(5'h12, v); chk("R7 addr lo after stream", v, 16'h0010);
    rd(5'h13, v); chk("R6 upper readback", v, 16'hC0E1);
    rd(5'h14, v); chk("R6 lower readback", v, 16'h0303);

    // R5 R9 R10 second image at 0x00100000 with toggling ready
    wr(5'h11, 16'h0010); wr(5'h12, 16'h0000);
    rd(5'h11, v); chk("R5 addr hi load", v, 16'h0010);
    ready_mode = 2;
    for (int i = 0; i < 6; i++) word(32'h5A00_1000 ^ 32'(i * 32'h0113_0007));
    wr(5'h14, 16'h4242);   // R8 second commit with no upper half
    drain();
    ready_mode = 1;
    rd(5'h12, v); chk("R7 addr lo second image", v, 16'h001C);

    // R7 carry across bit 16
    wr(5'h11, 16'h0000); wr(5'h12, 16'hFFFC);
    word(32'h1357_9BDF);
    drain();
    rd(5'h11, v); chk("R7 carry hi", v, 16'h0001);
    rd(5'h12, v); chk("R7 carry lo", v, 16'h0000);

    // R7 auto-increment off
    wr(5'h10, 16'h0000);
    word(32'h1111_2222); word(32'h3333_4444);
    drain();
    rd(5'h12, v); chk("R7 no increment", v, 16'h0000);
    rd(5'h10, v); chk("R4 mode cleared", v, 16'h0000);

    // R8 address load discards pending upper half
    wr(5'h10, 16'h8000);
    wr(5'h13, 16'h5555); wr(5'h12, 16'h0040); wr(5'h14, 16'h1111);
    drain();
    rd(5'h13, v); chk("R8 upper readback kept", v, 16'h5555);

    // R9 R10 back-pressure and same-cycle acceptance
    ready_mode = 0;
    repeat (2) @(posedge clk);
    word(32'hFEED_BEEF);
    @(negedge clk);
    chk("R10 reg_ready low", {mem_valid, reg_ready}, 2'b10);
    chk("R9 held word", {mem_addr, mem_data}, {32'h0001_0044, 32'hFEED_BEEF});
    @(negedge clk); reg_addr = 5'h13; reg_wdata = 16'h7777; reg_we = 1'b1;
    @(posedge clk); #1 reg_we = 1'b0;
    rd(5'h13, v); chk("R10 blocked write ignored", v, 16'hFEED);
    chk("R9 still held", {mem_valid, mem_addr, mem_data}, {1'b1, 32'h0001_0044, 32'hFEED_BEEF});
    fork
      wr(5'h13, 16'h9999);
      begin repeat (3) @(posedge clk); ready_mode = 1; end
    join
    chk("R10 same-cycle accept", acc_cyc, hs_cyc);
    wr(5'h14, 16'h8888);
    drain();
    rd(5'h13, v); chk("R10 queued upper taken", v, 16'h9999);

    // R11 release and start
    wr(5'h15, 16'h0001);
    @(negedge clk);
    chk("R11 start set", {cpu_hold, cpu_start}, 2'b01);
    rd(5'h15, v); chk("R11 run readback", v, 16'h0001);

    // R2 back to page 0
    wr(5'h1F, 16'h0000);
    rd(5'h1F, v); chk("R2 page 0", v, 0);
    rd(5'h15, v); chk("R2 window closed", v, 0);

    drain();
    chk("R6 all words delivered", {32'(pushed), 32'(exp_q.size())}, {32'(popped), 32'h0});
    finish_run();
  end
endmodule